// File: doc/BRIEF.md
# Trap-Aware Iteration Sequencer for an LDPC Decoder

This block paces the iterations of an iterative LDPC decoder whose datapath can clear out a detected trapping set once per frame. A frame opens with a start pulse, which also captures two run-time limits: the iteration budget and the length of a neutralization run, counted in iterations. The sequencer then starts iterations one at a time. After each one it reads the datapath's verdict, which is whether the hard decisions form a valid codeword and whether a stuck-syndrome trap was seen. From that verdict it ends the frame, starts another iteration, or starts a neutralization run.

A neutralization run is charged to the budget. The iteration count jumps by the run length when the run is launched. A run is launched only if a trap is flagged, no run has happened yet in this frame, and the count plus the run length is still below the budget. When no trap is ever flagged, the block acts as a plain fixed-budget iteration controller. The frame closes with a one-cycle finished pulse that carries a success flag.

The state machine has five states:
- IDLE: waiting for a frame start.
- ITERATE: waiting for the iteration-complete pulse.
- CHECK: a one-cycle decision.
- NEUTRALIZE: waiting for the neutralization-complete pulse.
- DONE: the one-cycle finish.

The transitions are:
- IDLE→ITERATE on start with a non-zero budget.
- IDLE→DONE on start with a zero budget.
- ITERATE→CHECK on iteration-complete.
- CHECK→DONE on a valid codeword or an exhausted budget.
- CHECK→NEUTRALIZE when a run is allowed.
- CHECK→ITERATE otherwise.
- NEUTRALIZE→ITERATE on neutralization-complete.
- DONE→IDLE always.

Top module: `nz_iter_ctrl`

## Requirements
- R1: While reset is held, and in IDLE with no start, `iter_go`, `nz_go`, `fin` and `fin_ok` are all 0.
- R2: A `frame_start` in IDLE with a non-zero budget raises `iter_go` in that same cycle, and the iteration count becomes 1 before the first iteration runs.
- R3: If `cw_valid` is 1 with an `iter_done` pulse, then two cycles after that pulse `fin` is 1 with `fin_ok` 1.
- R4: With no valid codeword and no trap, exactly `budget` iterations are started, and then `fin` rises with `fin_ok` 0.
- R5: If `trap_seen` is 1 with an `iter_done` pulse and a run is allowed, `nz_go` pulses in the very next cycle.
- R6: At most one `nz_go` occurs per frame, even when `trap_seen` stays 1 afterwards.
- R7: A run adds the run length to the iteration count. A failing frame that neutralizes therefore starts exactly `budget - nz_len` iterations.
- R8: A run is allowed only when count + `nz_len` < `budget`. With budget 64 and length 5, a trap at count 58 starts a run, but a trap at count 59 or 62 does not.
- R9: The cycle in which `nz_done` arrives in NEUTRALIZE raises `iter_go`.
- R10: `fin` is 1 for exactly one cycle per frame. `fin_ok` is never 1 without `fin`. At most one of `iter_go`, `nz_go` and `fin` is 1 in any cycle.
- R11: `budget_in` and `nz_len_in` are sampled only at frame start. Changing them later in the frame has no effect.
- R12: A `frame_start` that arrives while a frame is in progress is ignored.
- R13: A valid codeword takes priority over an exhausted budget and over a trap. A valid result on the last allowed iteration ends in success.
- R14: A start with a zero budget starts no iteration and finishes one cycle later with `fin_ok` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | Opens a frame when IDLE |
| budget_in | input | CW | Maximum iteration count, sampled at start |
| nz_len_in | input | CW | Iterations charged per neutralization, sampled at start |
| iter_done | input | 1 | Datapath finished the current iteration |
| cw_valid | input | 1 | Syndrome zero, qualified by iter_done |
| trap_seen | input | 1 | Trap detected, qualified by iter_done |
| nz_done | input | 1 | Datapath finished neutralization |
| iter_go | output | 1 | Start one decoding iteration |
| nz_go | output | 1 | Start a neutralization run |
| fin | output | 1 | Frame finished, one cycle |
| fin_ok | output | 1 | Frame decoded successfully, valid with fin |

## Verification
The embedded assertions watch properties that hold on every cycle:
- the finish pulse lasts one cycle;
- the three output pulses never overlap;
- a quiet IDLE stays quiet;
- a second run is never marked in one frame;
- a launched run always fits the budget;
- the count never passes the budget.

Only the directed scenarios can show the end-to-end arithmetic. That covers how many iterations a frame uses with and without a run, the boundary at count + length = budget, and that limits and starts arriving mid-frame are ignored. It also covers the latency from an iteration verdict to `nz_go` or `fin`.

// File: rtl/nz_iter_pkg.sv
package nz_iter_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ITERATE,
        ST_CHECK,
        ST_NEUTRALIZE,
        ST_DONE
    } ctl_state_t;

endpackage

// File: rtl/nzc_budget.sv
// Iteration budget: captures the limits at frame start, counts iterations,
// and charges a neutralization run as a jump of nt_q.
module nzc_budget #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] max_in,
    input  logic [CW-1:0] nt_in,
    input  logic          step,
    input  logic          jump,
    output logic          exhausted,
    output logic          room
);
    localparam int SW = CW + 1;

    logic [CW-1:0] max_q;
    logic [CW-1:0] nt_q;
    logic [CW-1:0] cnt_q;
    logic [SW-1:0] reach;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            max_q <= '0;
            nt_q  <= '0;
            cnt_q <= '0;
        end else if (load) begin
            max_q <= max_in;
            nt_q  <= nt_in;
            cnt_q <= step ? CW'(1) : '0;
        end else if (jump) begin
            cnt_q <= cnt_q + nt_q;
        end else if (step) begin
            cnt_q <= cnt_q + CW'(1);
        end
    end

    assign reach     = {1'b0, cnt_q} + {1'b0, nt_q};
    assign exhausted = (cnt_q >= max_q);
    assign room      = (reach < {1'b0, max_q});

    // R7: charging never carries the count past the budget
    assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= max_q);

    // R8: a jump is only requested when the run fits inside the budget
    assert_jump_fits_R8: assert property (@(posedge clk) disable iff (!rst_n)
        jump |-> ({1'b0, cnt_q} + {1'b0, nt_q} < {1'b0, max_q}));

endmodule

// File: rtl/nzc_flags.sv
// Iteration verdict latch and per-frame neutralization-used marker.
module nzc_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic capture,
    input  logic valid_in,
    input  logic trap_in,
    input  logic mark_nz,
    output logic valid_q,
    output logic trap_q,
    output logic used_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            trap_q  <= 1'b0;
        end else if (clear) begin
            valid_q <= 1'b0;
            trap_q  <= 1'b0;
        end else if (capture) begin
            valid_q <= valid_in;
            trap_q  <= trap_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            used_q <= 1'b0;
        end else if (clear) begin
            used_q <= 1'b0;
        end else if (mark_nz) begin
            used_q <= 1'b1;
        end
    end

    // R6: a second run is never marked within one frame
    assert_single_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
        mark_nz |-> !used_q);

endmodule

// File: rtl/nz_iter_ctrl.sv
module nz_iter_ctrl
    import nz_iter_pkg::*;
#(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic [CW-1:0] budget_in,
    input  logic [CW-1:0] nz_len_in,
    input  logic          iter_done,
    input  logic          cw_valid,
    input  logic          trap_seen,
    input  logic          nz_done,
    output logic          iter_go,
    output logic          nz_go,
    output logic          fin,
    output logic          fin_ok
);
    ctl_state_t state_q;
    ctl_state_t state_d;

    logic exhausted;
    logic room;
    logic valid_q;
    logic trap_q;
    logic used_q;
    logic ok_q;

    logic start_run;
    logic start_zero;
    logic chk_pass;
    logic chk_fail;
    logic chk_nz;
    logic chk_more;
    logic resume;
    logic capture;

    nzc_budget #(.CW(CW)) u_budget (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (state_q == ST_IDLE && frame_start),
        .max_in    (budget_in),
        .nt_in     (nz_len_in),
        .step      (iter_go),
        .jump      (chk_nz),
        .exhausted (exhausted),
        .room      (room)
    );

    nzc_flags u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (state_q == ST_IDLE && frame_start),
        .capture  (capture),
        .valid_in (cw_valid),
        .trap_in  (trap_seen),
        .mark_nz  (chk_nz),
        .valid_q  (valid_q),
        .trap_q   (trap_q),
        .used_q   (used_q)
    );

    // decision terms
    always_comb begin
        start_run  = (state_q == ST_IDLE) && frame_start && (budget_in != '0);
        start_zero = (state_q == ST_IDLE) && frame_start && (budget_in == '0);
        capture    = (state_q == ST_ITERATE) && iter_done;
        chk_pass   = (state_q == ST_CHECK) && valid_q;
        chk_fail   = (state_q == ST_CHECK) && !valid_q && exhausted;
        chk_nz     = (state_q == ST_CHECK) && !valid_q && !exhausted
                     && trap_q && !used_q && room;
        chk_more   = (state_q == ST_CHECK) && !valid_q && !exhausted && !chk_nz;
        resume     = (state_q == ST_NEUTRALIZE) && nz_done;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ok_q <= 1'b0;
        end else if (start_zero || chk_fail) begin
            ok_q <= 1'b0;
        end else if (chk_pass) begin
            ok_q <= 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_run)       state_d = ST_ITERATE;
                else if (start_zero) state_d = ST_DONE;
            end
            ST_ITERATE: begin
                if (iter_done) state_d = ST_CHECK;
            end
            ST_CHECK: begin
                if (chk_pass || chk_fail) state_d = ST_DONE;
                else if (chk_nz)          state_d = ST_NEUTRALIZE;
                else                      state_d = ST_ITERATE;
            end
            ST_NEUTRALIZE: begin
                if (nz_done) state_d = ST_ITERATE;
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        iter_go = start_run || chk_more || resume;
        nz_go   = chk_nz;
        fin     = (state_q == ST_DONE);
        fin_ok  = (state_q == ST_DONE) && ok_q;
    end

    // R10: output pulses are mutually exclusive
    assert_pulse_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({iter_go, nz_go, fin}));

    // R10: finish never lasts two cycles
    assert_fin_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fin |=> !fin);

    // R1: an idle sequencer with no start stays silent
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !frame_start) |-> (!iter_go && !nz_go && !fin));

    // R5: a run is launched only on a trap verdict that was not a valid codeword
    assert_nz_cause_R5: assert property (@(posedge clk) disable iff (!rst_n)
        nz_go |-> (trap_q && !valid_q));

    // R9: the cycle after nz_go is spent waiting, never issuing
    assert_nz_then_wait_R9: assert property (@(posedge clk) disable iff (!rst_n)
        nz_go |=> (state_q == ST_NEUTRALIZE));

endmodule

// File: tb/test_nz_iter_ctrl.sv
module test_nz_iter_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic [CW-1:0] budget_in = '0;
    logic [CW-1:0] nz_len_in = '0;
    logic          iter_done = 1'b0;
    logic          cw_valid = 1'b0;
    logic          trap_seen = 1'b0;
    logic          nz_done = 1'b0;
    logic          iter_go;
    logic          nz_go;
    logic          fin;
    logic          fin_ok;

    int n_checks = 0;
    int n_fail = 0;

    // per-frame observations
    int n_iter, n_nz, n_fin, lat_fin, lat_nz;
    bit ok_seen, first_go_same, resume_bad, bad_ok, timed_out;

    always #(CLK_PERIOD/2) clk = ~clk;

    nz_iter_ctrl #(.CW(CW)) i_nz_iter_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .budget_in   (budget_in),
        .nz_len_in   (nz_len_in),
        .iter_done   (iter_done),
        .cw_valid    (cw_valid),
        .trap_seen   (trap_seen),
        .nz_done     (nz_done),
        .iter_go     (iter_go),
        .nz_go       (nz_go),
        .fin         (fin),
        .fin_ok      (fin_ok)
    );

    task automatic chk(input bit good, input string req, input int act, input int exp);
        n_checks++;
        if (!good) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Drives one frame and plays the datapath: iter_done two cycles after
    // iter_go, nz_done three cycles after nz_go. Flags follow the bench's own
    // iteration count model (iterations plus charged run lengths).
    task automatic run_frame(input int mx, input int nt, input int valid_at,
                             input int trap_from, input bit disturb);
        int mcnt = 0;
        int it_wait = 0;
        int nz_wait = 0;
        int last_done = 0;
        int fin_cyc = 0;
        bit pv = 0;
        bit pt = 0;
        n_iter = 0; n_nz = 0; n_fin = 0; lat_fin = -1; lat_nz = -1;
        ok_seen = 0; first_go_same = 0; resume_bad = 0; bad_ok = 0; timed_out = 1;
        for (int cyc = 0; cyc < 3000; cyc++) begin
            @(negedge clk);
            frame_start = (cyc == 0) || (disturb && cyc == 3);
            if (cyc == 0) begin
                budget_in = CW'(mx);
                nz_len_in = CW'(nt);
            end else if (disturb && cyc == 3) begin
                budget_in = CW'(3);
                nz_len_in = CW'(1);
            end
            iter_done = 0; nz_done = 0; cw_valid = 0; trap_seen = 0;
            if (it_wait > 0) begin
                it_wait--;
                if (it_wait == 0) begin
                    iter_done = 1; cw_valid = pv; trap_seen = pt; last_done = cyc;
                end
            end
            if (nz_wait > 0) begin
                nz_wait--;
                if (nz_wait == 0) nz_done = 1;
            end
            #1;
            if (fin_ok && !fin) bad_ok = 1;
            if (nz_done && !iter_go) resume_bad = 1;
            if (iter_go) begin
                if (cyc == 0) first_go_same = 1;
                mcnt++; n_iter++;
                pv = (valid_at > 0) && (mcnt >= valid_at);
                pt = (trap_from > 0) && (mcnt >= trap_from);
                it_wait = 2;
            end
            if (nz_go) begin
                n_nz++; mcnt += nt; nz_wait = 3; lat_nz = cyc - last_done;
            end
            if (fin) begin
                n_fin++; ok_seen = fin_ok; lat_fin = cyc - last_done; fin_cyc = cyc;
            end
            if (n_fin > 0 && cyc >= fin_cyc + 4) begin
                timed_out = 0;
                break;
            end
        end
        frame_start = 0;
        chk(!timed_out, "frame completion", int'(timed_out), 0);
    endtask

    task automatic t_reset();
        #1;
        chk(!iter_go && !nz_go && !fin && !fin_ok, "R1 in reset",
            int'({iter_go, nz_go, fin, fin_ok}), 0);
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1;
        repeat (2) @(negedge clk);
        #1;
        chk(!iter_go && !nz_go && !fin && !fin_ok, "R1 idle after reset",
            int'({iter_go, nz_go, fin, fin_ok}), 0);
    endtask

    task automatic t_plain_fail();
        run_frame(10, 3, 0, 0, 0);
        chk(first_go_same, "R2 iter_go with start", int'(first_go_same), 1);
        chk(n_iter == 10, "R4 iterations to budget", n_iter, 10);
        chk(!ok_seen && n_nz == 0, "R4 failure status", int'(ok_seen), 0);
        chk(n_fin == 1 && !bad_ok, "R10 single finish", n_fin, 1);
    endtask

    task automatic t_success();
        run_frame(10, 3, 4, 0, 0);
        chk(n_iter == 4 && ok_seen, "R3 success at iteration 4", n_iter, 4);
        chk(lat_fin == 2, "R3 finish latency", lat_fin, 2);
    endtask

    task automatic t_neutralize_fail();
        run_frame(20, 5, 0, 3, 0);
        chk(n_nz == 1, "R6 one run despite persistent trap", n_nz, 1);
        chk(lat_nz == 1, "R5 nz_go latency", lat_nz, 1);
        chk(n_iter == 15, "R7 budget charged", n_iter, 15);
        chk(!resume_bad, "R9 iter_go with nz_done", int'(resume_bad), 0);
        chk(!ok_seen, "R7 failure status", int'(ok_seen), 0);
    endtask

    task automatic t_neutralize_success();
        run_frame(20, 5, 9, 2, 0);
        chk(n_nz == 1 && n_iter == 4, "R5 run then success", n_iter, 4);
        chk(ok_seen, "R3 success after run", int'(ok_seen), 1);
    endtask

    task automatic t_boundary();
        run_frame(64, 5, 0, 62, 0);
        chk(n_nz == 0 && n_iter == 64, "R8 trap at 62 blocked", n_nz, 0);
        run_frame(64, 5, 0, 59, 0);
        chk(n_nz == 0 && n_iter == 64, "R8 trap at 59 blocked", n_nz, 0);
        run_frame(64, 5, 0, 58, 0);
        chk(n_nz == 1 && n_iter == 59, "R8 trap at 58 allowed", n_iter, 59);
    endtask

    task automatic t_last_valid();
        run_frame(6, 2, 6, 5, 0);
        chk(ok_seen && n_iter == 6, "R13 valid on final iteration", int'(ok_seen), 1);
    endtask

    task automatic t_zero_budget();
        run_frame(0, 2, 0, 0, 0);
        chk(n_iter == 0 && !ok_seen && n_fin == 1, "R14 zero budget", n_iter, 0);
        chk(lat_fin == 1, "R14 finish latency", lat_fin, 1);
    endtask

    task automatic t_disturb();
        run_frame(8, 2, 0, 0, 1);
        chk(n_iter == 8, "R11 limits held from start", n_iter, 8);
        chk(n_fin == 1, "R12 mid-frame start ignored", n_fin, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        summary();
    end

    initial begin
        t_reset();
        t_plain_fail();
        t_success();
        t_neutralize_fail();
        t_neutralize_success();
        t_boundary();
        t_last_valid();
        t_zero_budget();
        t_disturb();
        summary();
    end

endmodule